// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Direction Override

This block controls one parallel I/O port of `WIDTH` pins. Software sees four byte-wide locations on a simple strobe-based register bus: an output data latch, a direction register, a drive-strength register and a read-only view of the synchronized pad inputs. For every pin the block produces an output enable, an output data bit and a reduced-strength select for the pad wrapper.

Each pin's direction is decided by a fixed priority chain. A serial transmit enable for a pin forces it to drive. Failing that, a serial receive enable forces it to listen. Failing that, if the SPI is enabled and the pin belongs to the SPI (per the `SPI_PIN_MASK` parameter), the SPI's own direction bit decides. Otherwise the direction register decides. When an override drops away, the stored direction bit takes over again with no rewrite needed.

Pad inputs pass through a synchronizer of `SYNC_STAGES` flops before any register read can see them. Reads return their data on the clock after the read strobe. As a result, a read issued just after a direction change or a pad change can show the old value for up to two bus clocks.

Top module: `gpioPort`

## Requirements
- R1: After reset the data, direction and drive registers hold zero, every pin is an input (`pinOe` = 0), `pinReduced` = 0 and `busRdData` = 0.
- R2: With no override active on a pin, a direction bit of 1 makes that pin an output and a bit of 0 makes it an input.
- R3: While `spiEn` = 1, each pin whose bit is set in `SPI_PIN_MASK` takes its direction from `spiDirOut` and ignores the direction register. Pins outside the mask keep following the direction register.
- R4: While `sciTxEn[i]` = 1, pin i is an output, whatever the direction register, the SPI or `sciRxEn[i]` say.
- R5: While `sciRxEn[i]` = 1 and `sciTxEn[i]` = 0, pin i is an input, whatever the direction register or the SPI say.
- R6: When every override on a pin is removed, the pin returns at once to the direction held in the direction register, without the register being written again.
- R7: `pinReduced[i]` equals drive-register bit i while pin i is an output, and is 0 while pin i is an input.
- R8: A write with `busWrEn` = 1 loads `busWrData` at the clock edge: address 0 loads the data latch, 1 the direction register, 2 the drive register. A write to address 3 or to any address with a nonzero bit above bit 1 changes nothing. A read with `busRdEn` = 1 at an edge places the addressed value on `busRdData` after that edge. An unmapped address reads 0. `busRdData` holds its value when there is no read.
- R9: Reading address 3 returns the pad inputs as they were two clocks before the read edge (two-stage synchronizer).
- R10: Reading address 0 returns, per bit, the data latch for pins currently acting as outputs and the synchronized pad value for pins acting as inputs.
- R11: `pinOut` always equals the data latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Single-cycle write strobe |
| busRdEn | input | 1 | Single-cycle read strobe |
| busAddr | input | ADDR_W | Register address |
| busWrData | input | WIDTH | Write data |
| busRdData | output | WIDTH | Registered read data |
| spiEn | input | 1 | SPI enabled, claims pins in SPI_PIN_MASK |
| spiDirOut | input | WIDTH | SPI per-pin direction, 1 = output |
| sciTxEn | input | WIDTH | Per-pin serial transmit enable |
| sciRxEn | input | WIDTH | Per-pin serial receive enable |
| padIn | input | WIDTH | Raw pad input values |
| pinOe | output | WIDTH | Per-pin output enable |
| pinOut | output | WIDTH | Per-pin output data |
| pinReduced | output | WIDTH | Per-pin reduced drive select |

## Verification
The bench builds the block with `WIDTH` = 8, `ADDR_W` = 4, `SPI_PIN_MASK` = 8'h3C and `SYNC_STAGES` = 2. The 4-bit address makes the unmapped range above the four registers reachable, so writes and reads there can be checked to have no effect and to return 0. The mask leaves pins on both sides of the SPI claim, so the same `spiEn` pulse can be seen taking over some pins while the rest stay with the direction register. It also lets transmit and receive enables collide with the SPI claim on the same pin. Two synchronizer stages fix the readback lag at two clocks, and the reference model tracks that lag against random pad activity.

// File: rtl/gpioPortPkg.sv
package gpioPortPkg;

  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_DRIVE = 2'd2,
    SEL_INPUT = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    logic    wrDrive;
    logic    rdLoad;
    logic    rdHit;
    regSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/gpioPortSync.sv
module gpioPortSync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= din;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/gpioPortCtrl.sv
module gpioPortCtrl
  import gpioPortPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);

  logic    addrHit;
  regSel_e sel;

  generate
    if (ADDR_W > 2) begin : g_wideAddr
      localparam int HI = ADDR_W - 1;
      assign addrHit = (busAddr[HI:2] == '0);
    end else begin : g_narrowAddr
      assign addrHit = 1'b1;
    end
  endgenerate

  assign sel = regSel_e'(busAddr[1:0]);

  always_comb begin
    strobe         = '0;
    strobe.wrData  = busWrEn && addrHit && (sel == SEL_DATA);
    strobe.wrDir   = busWrEn && addrHit && (sel == SEL_DIR);
    strobe.wrDrive = busWrEn && addrHit && (sel == SEL_DRIVE);
    strobe.rdLoad  = busRdEn;
    strobe.rdHit   = addrHit;
    strobe.rdSel   = sel;
  end

endmodule

// File: rtl/gpioPortDatapath.sv
module gpioPortDatapath
  import gpioPortPkg::*;
#(
  parameter int               WIDTH        = 8,
  parameter logic [WIDTH-1:0] SPI_PIN_MASK = 8'h3C,
  parameter int               SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStrobe_t       strobe,
  input  logic [WIDTH-1:0] wrData,
  input  logic             spiEn,
  input  logic [WIDTH-1:0] spiDirOut,
  input  logic [WIDTH-1:0] sciTxEn,
  input  logic [WIDTH-1:0] sciRxEn,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] pinOe,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinReduced,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] dataReg;
  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] driveReg;
  logic [WIDTH-1:0] padSync;
  logic [WIDTH-1:0] baseDir;
  logic [WIDTH-1:0] readMux;

  // register storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      dirReg   <= '0;
      driveReg <= '0;
    end else begin
      if (strobe.wrData)  dataReg  <= wrData;
      if (strobe.wrDir)   dirReg   <= wrData;
      if (strobe.wrDrive) driveReg <= wrData;
    end
  end

  gpioPortSync #(
    .WIDTH  (WIDTH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (padIn),
    .dout (padSync)
  );

  // per-pin direction priority: transmit, receive, SPI, register
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_pin
      if (SPI_PIN_MASK[i]) begin : g_spiPin
        assign baseDir[i] = spiEn ? spiDirOut[i] : dirReg[i];
      end else begin : g_plainPin
        assign baseDir[i] = dirReg[i];
      end
      assign pinOe[i] = sciTxEn[i] | (~sciRxEn[i] & baseDir[i]);
    end
  endgenerate

  assign pinOut     = dataReg;
  assign pinReduced = driveReg & pinOe;

  always_comb begin
    readMux = '0;
    if (strobe.rdHit) begin
      unique case (strobe.rdSel)
        SEL_DATA:  readMux = (dataReg & pinOe) | (padSync & ~pinOe);
        SEL_DIR:   readMux = dirReg;
        SEL_DRIVE: readMux = driveReg;
        SEL_INPUT: readMux = padSync;
        default:   readMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rdData <= '0;
    else if (strobe.rdLoad) rdData <= readMux;
  end

  // ---------------- assertions ----------------
  logic [1:0] ageCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ageCnt <= '0;
    else if (ageCnt != 2'd3) ageCnt <= ageCnt + 2'd1;
  end

  AST_TX_FORCES_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (sciTxEn & ~pinOe) == '0); // R4

  AST_RX_FORCES_IN: assert property (@(posedge clk) disable iff (!rstN)
    (sciRxEn & ~sciTxEn & pinOe) == '0); // R5

  AST_FREE_PIN_FOLLOWS_REG: assert property (@(posedge clk) disable iff (!rstN)
    ((~sciTxEn & ~sciRxEn & ~(spiEn ? SPI_PIN_MASK : '0)) & (pinOe ^ dirReg)) == '0); // R6

  AST_DRIVE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (pinReduced & ~pinOe) == '0); // R7

  AST_READ_DIR_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdLoad && strobe.rdHit && strobe.rdSel == SEL_DIR) |=> rdData == $past(dirReg)); // R8

  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (ageCnt != 2'd0 && !$past(strobe.rdLoad)) |-> $stable(rdData)); // R8

  generate
    if (SYNC_STAGES == 2) begin : g_lagCheck
      AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rstN)
        (ageCnt >= 2'd2) |-> padSync == $past(padIn, 2)); // R9
    end
  endgenerate

endmodule

// File: rtl/gpioPort.sv
module gpioPort
  import gpioPortPkg::*;
#(
  parameter int               WIDTH        = 8,
  parameter int               ADDR_W       = 4,
  parameter logic [WIDTH-1:0] SPI_PIN_MASK = 8'h3C,
  parameter int               SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic              spiEn,
  input  logic [WIDTH-1:0]  spiDirOut,
  input  logic [WIDTH-1:0]  sciTxEn,
  input  logic [WIDTH-1:0]  sciRxEn,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  pinOe,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinReduced
);

  busStrobe_t strobe;

  gpioPortCtrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  gpioPortDatapath #(
    .WIDTH        (WIDTH),
    .SPI_PIN_MASK (SPI_PIN_MASK),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (busWrData),
    .spiEn      (spiEn),
    .spiDirOut  (spiDirOut),
    .sciTxEn    (sciTxEn),
    .sciRxEn    (sciRxEn),
    .padIn      (padIn),
    .pinOe      (pinOe),
    .pinOut     (pinOut),
    .pinReduced (pinReduced),
    .rdData     (busRdData)
  );

endmodule

// File: tb/test_gpioPort.sv
`timescale 1ns/1ps
module test_gpioPort;

  localparam int W = 8;
  localparam int A = 4;
  localparam logic [W-1:0] MASK = 8'h3C;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWrEn = 1'b0, busRdEn = 1'b0;
  logic [A-1:0] busAddr = '0;
  logic [W-1:0] busWrData = '0, busRdData;
  logic         spiEn = 1'b0;
  logic [W-1:0] spiDirOut = '0, sciTxEn = '0, sciRxEn = '0, padIn = '0;
  logic [W-1:0] pinOe, pinOut, pinReduced;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpioPort #(.WIDTH(W), .ADDR_W(A), .SPI_PIN_MASK(MASK), .SYNC_STAGES(2)) i_gpioPort (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .spiEn(spiEn), .spiDirOut(spiDirOut),
    .sciTxEn(sciTxEn), .sciRxEn(sciRxEn), .padIn(padIn), .pinOe(pinOe), .pinOut(pinOut),
    .pinReduced(pinReduced));

  // behavioural reference model
  logic [W-1:0] mData = '0, mDir = '0, mDrive = '0, mRd = '0;
  logic [W-1:0] padHist [$];

  function automatic logic [W-1:0] expOe();
    logic [W-1:0] r;
    for (int p = 0; p < W; p++) begin
      if (sciTxEn[p])                r[p] = 1'b1;
      else if (sciRxEn[p])           r[p] = 1'b0;
      else if (spiEn && MASK[p])     r[p] = spiDirOut[p];
      else                           r[p] = mDir[p];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] syncedPad();
    return padHist[0];
  endfunction

  initial begin
    padHist.push_back('0);
    padHist.push_back('0);
  end

  always @(posedge clk) begin
    logic [W-1:0] oe;
    if (!rstN) begin
      mData = '0; mDir = '0; mDrive = '0; mRd = '0;
      padHist = {};
      padHist.push_back('0);
      padHist.push_back('0);
    end else begin
      oe = expOe();
      if (busRdEn) begin
        if (busAddr >= 4) mRd = '0;
        else case (busAddr)
          0: mRd = (mData & oe) | (syncedPad() & ~oe);
          1: mRd = mDir;
          2: mRd = mDrive;
          default: mRd = syncedPad();
        endcase
      end
      if (busWrEn) begin
        if (busAddr == 0) mData = busWrData;
        else if (busAddr == 1) mDir = busWrData;
        else if (busAddr == 2) mDrive = busWrData;
      end
      void'(padHist.pop_front());
      padHist.push_back(padIn);
    end
  end

  task automatic check(string label, logic [W-1:0] act, logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", label, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("R2 R3 R4 R5 R6 pinOe", pinOe, expOe());
      check("R11 pinOut", pinOut, mData);
      check("R7 pinReduced", pinReduced, mDrive & expOe());
      check("R8 R9 R10 busRdData", busRdData, mRd);
    end
  end

  task automatic busOp(bit we, bit re, int addr, logic [W-1:0] d);
    @(posedge clk); #1;
    busWrEn = we; busRdEn = re; busAddr = A'(addr); busWrData = d;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) busOp(0, 0, 0, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 pinOe after reset", pinOe, '0);
    check("R1 pinReduced after reset", pinReduced, '0);
    check("R1 busRdData after reset", busRdData, '0);
    busOp(0, 1, 1, '0); busOp(0, 1, 2, '0); busOp(0, 1, 0, '0);
    idle(1);
    check("R1 dir/drive read zero", busRdData, mRd);

    // R2 R8 R11: plain writes
    busOp(1, 0, 1, 8'hF0); busOp(1, 0, 2, 8'hAA); busOp(1, 0, 0, 8'h5A);
    busOp(1, 0, 3, 8'hFF); busOp(1, 0, 5, 8'hFF); busOp(1, 0, 4'hE, 8'h00);
    busOp(0, 1, 1, '0); busOp(0, 1, 2, '0); busOp(0, 1, 6, '0); idle(1);
    check("R8 unmapped read zero", busRdData, 8'h00);

    // R3: SPI claim
    busOp(0, 0, 0, '0); spiEn = 1; spiDirOut = 8'h0F;
    idle(3);
    // R4 R5: serial channels override SPI and register
    busOp(0, 0, 0, '0); sciTxEn = 8'h05; sciRxEn = 8'hA4;
    idle(3);
    // R6: release all
    busOp(0, 0, 0, '0); spiEn = 0; sciTxEn = '0; sciRxEn = '0;
    idle(2);
    check("R6 dir restored", pinOe, 8'hF0);

    // R9 R10: pad changes and read timing
    busOp(0, 1, 3, '0); padIn = 8'h3C;
    busOp(0, 1, 3, '0); busOp(0, 1, 3, '0); busOp(0, 1, 3, '0);
    busOp(0, 1, 0, '0); busOp(1, 0, 1, 8'h0F); busOp(0, 1, 0, '0);
    busOp(0, 1, 0, '0); idle(2);
    check("R10 port read mix", busRdData, (mData & 8'h0F) | (8'h3C & 8'hF0));

    // random phase
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom_range(0, 9);
      busOp(r < 3, (r >= 3 && r < 7), $urandom_range(0, 15), W'($urandom));
      padIn = W'($urandom);
      if ($urandom_range(0, 7) == 0) spiEn = ~spiEn;
      spiDirOut = W'($urandom);
      sciTxEn = W'($urandom & $urandom & $urandom);
      sciRxEn = W'($urandom & $urandom);
    end
    idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule